// File: doc/BRIEF.md
# Stream Table Entry Configuration Decoder

This block takes one stream table entry, already fetched by its neighbour, and works out the translation set-up that the entry asks for. It classifies the entry as aborting, bypassing or translating, and reports which of the two translation stages are on. When the second stage is on, it derives the effective output address width of that stage and checks the stage's input-size field against it. It also checks the stage's table base address against that width. Any malformed entry is reported through a single bad-entry flag.

Requests enter on a valid/ready pair. `req_ready` is high whenever the one-deep result register is empty, or is being drained in the same cycle. A request is taken on a rising edge with `req_valid` and `req_ready` both high. Its decoded result appears on the next edge with `rsp_valid` high. The result stays frozen for as long as `rsp_ready` is held low. The entry fields only need to be valid during the accepting cycle.

A separate static control, `cap_sel`, selects which stages the instance advertises and drives two identification bits directly.

Top module: `ste_cfg_decoder`

## Requirements
- R1: After reset `rsp_valid` is 0. `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request's result appears with `rsp_valid` high one clock after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the result fields and `rsp_valid` hold unchanged.
- R2: An entry with `ent_valid` = 0 gives `rsp_bad` = 1, with every other flag at 0, `rsp_eff_ps` = 0 and `rsp_t0sz_ok` = 0, whatever `ent_cfg` holds.
- R3: `ent_cfg` = 3'b000 gives `rsp_abort` = 1 and nothing else set. No stage checks are made, so even an out-of-range base leaves `rsp_bad` = 0.
- R4: `ent_cfg` = 3'b100 gives `rsp_bypass` = 1 and nothing else set, again with no stage checks.
- R5: `ent_cfg` = 3'b101 sets only `rsp_s1`; 3'b110 sets only `rsp_s2`; 3'b111 sets both (nested). When stage 2 is off, `rsp_eff_ps` = 0, `rsp_t0sz_ok` = 0 and `rsp_bad` = 0.
- R6: `ent_cfg` values 3'b001, 3'b010 and 3'b011 give `rsp_bad` = 1 and clear all the other flags.
- R7: A 3-bit size code maps to a bit count as follows: 0→32, 1→36, 2→40, 3→42, 4→44, 5→48, 6→52, 7→52.
- R8: With stage 2 on, the effective width starts as the bit count of min(`s2_ps`, `impl_oas`).
- R9: When `s2_gran` is not 2'b01 (64KB), the effective width is further capped at 48.
- R10: With `s2_gran` = 2'b01, `rsp_t0sz_ok` = (`s2_t0sz` ≥ 64 − eff). With any other granule, `rsp_t0sz_ok` = (`s2_t0sz` ≥ max(64 − eff, 16)).
- R11: With stage 2 on, `rsp_bad` = 1 exactly when `s2_base` has any bit set at or above position eff.
- R12: `cap_sel` 2'b00 (and 2'b11) sets only `cap_s1`; 2'b01 sets only `cap_s2`; 2'b10 (nested) sets both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_sel | input | 2 | Advertised stage capability |
| cap_s1 | output | 1 | Stage-1 identification bit |
| cap_s2 | output | 1 | Stage-2 identification bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| ent_valid | input | 1 | Entry valid bit |
| ent_cfg | input | 3 | Entry configuration code |
| s2_gran | input | 2 | Stage-2 granule code (2'b01 = 64KB) |
| s2_ps | input | 3 | Stage-2 output size code |
| s2_t0sz | input | 6 | Stage-2 input size field |
| s2_base | input | 64 | Stage-2 table base address |
| impl_oas | input | 3 | Implemented output size code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_abort | output | 1 | Entry aborts traffic |
| rsp_bypass | output | 1 | Entry bypasses translation |
| rsp_s1 | output | 1 | Stage 1 enabled |
| rsp_s2 | output | 1 | Stage 2 enabled |
| rsp_eff_ps | output | 7 | Effective stage-2 output width in bits |
| rsp_t0sz_ok | output | 1 | Stage-2 input size field valid |
| rsp_bad | output | 1 | Entry malformed |

## Verification
Random entries mix every configuration code, granule, size-code pair, input-size value and base position. This tells apart which of the two size codes wins the minimum, and whether the 48-bit cap or the 16 floor applies. Directed entries sit exactly on the input-size threshold and one below it, with the 64KB granule and with the 4KB granule. They also place a single base bit at the effective width and just beneath it. Aborting and bypassing entries carry all-ones bases, and invalid entries carry a stage-2 code, to show that the lower-priority checks are masked. A held-off consumer, with a second request waiting, shows that the result stays frozen and that the queued request is taken on the draining edge.

// File: rtl/ste_dec_pkg.sv
package ste_dec_pkg;
  localparam int CFG_W = 3;
  localparam int CODE_W = 3;
  localparam int EFF_W = 7;

  localparam logic [CFG_W-1:0] CFG_ABORT  = 3'b000;
  localparam logic [CFG_W-1:0] CFG_BYPASS = 3'b100;
  localparam logic [CFG_W-1:0] CFG_S1     = 3'b101;
  localparam logic [CFG_W-1:0] CFG_S2     = 3'b110;
  localparam logic [CFG_W-1:0] CFG_NEST   = 3'b111;

  localparam logic [1:0] GRAN_64K = 2'b01;
  localparam logic [1:0] CAP_S1   = 2'b00;
  localparam logic [1:0] CAP_S2   = 2'b01;
  localparam logic [1:0] CAP_NEST = 2'b10;

  typedef struct packed {
    logic             abort;
    logic             bypass;
    logic             s1_en;
    logic             s2_en;
    logic [EFF_W-1:0] eff_ps;
    logic             t0sz_ok;
    logic             bad;
  } ste_res_t;

  function automatic logic [EFF_W-1:0] code_to_bits(input logic [CODE_W-1:0] c);
    logic [EFF_W-1:0] b;
    case (c)
      3'd0:    b = 7'd32;
      3'd1:    b = 7'd36;
      3'd2:    b = 7'd40;
      3'd3:    b = 7'd42;
      3'd4:    b = 7'd44;
      3'd5:    b = 7'd48;
      default: b = 7'd52;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/ste_cfg_class.sv
module ste_cfg_class
  import ste_dec_pkg::*;
(
  input  logic             ent_valid,
  input  logic [CFG_W-1:0] ent_cfg,
  output logic             is_abort,
  output logic             is_bypass,
  output logic             s1_on,
  output logic             s2_on,
  output logic             cfg_bad
);
  always_comb begin
    is_abort  = 1'b0;
    is_bypass = 1'b0;
    s1_on     = 1'b0;
    s2_on     = 1'b0;
    cfg_bad   = 1'b0;
    if (!ent_valid) begin
      cfg_bad = 1'b1;
    end else if (ent_cfg == CFG_ABORT) begin
      is_abort = 1'b1;
    end else if (ent_cfg == CFG_BYPASS) begin
      is_bypass = 1'b1;
    end else if (ent_cfg[2]) begin
      s1_on = ent_cfg[0];
      s2_on = ent_cfg[1];
    end else begin
      cfg_bad = 1'b1;
    end
  end
endmodule

// File: rtl/ste_s2_size.sv
module ste_s2_size
  import ste_dec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int T0SZ_W = 6
) (
  input  logic [1:0]        gran,
  input  logic [CODE_W-1:0] ps_code,
  input  logic [CODE_W-1:0] impl_code,
  input  logic [T0SZ_W-1:0] t0sz,
  input  logic [ADDR_W-1:0] base,
  output logic [EFF_W-1:0]  eff_ps,
  output logic              t0sz_ok,
  output logic              base_oob
);
  localparam logic [EFF_W-1:0] CAP_SMALL_GRAN = 7'd48;
  localparam logic [EFF_W-1:0] T0SZ_FLOOR     = 7'd16;
  localparam logic [EFF_W-1:0] VA_TOP         = 7'd64;

  logic [CODE_W-1:0] min_code;
  logic [EFF_W-1:0]  raw_bits;
  logic              big_gran;
  logic [EFF_W-1:0]  lim;
  logic [EFF_W-1:0]  floor_v;
  logic [ADDR_W-1:0] hi_mask;

  assign big_gran = (gran == GRAN_64K);
  assign min_code = (ps_code < impl_code) ? ps_code : impl_code;
  assign raw_bits = code_to_bits(min_code);

  always_comb begin
    eff_ps = raw_bits;
    if (!big_gran && (raw_bits > CAP_SMALL_GRAN)) eff_ps = CAP_SMALL_GRAN;
  end

  assign lim     = VA_TOP - eff_ps;
  assign floor_v = (!big_gran && (lim < T0SZ_FLOOR)) ? T0SZ_FLOOR : lim;
  assign t0sz_ok = ({{(EFF_W-T0SZ_W){1'b0}}, t0sz} >= floor_v);

  assign hi_mask  = ~((ADDR_W'(1) << eff_ps) - ADDR_W'(1));
  assign base_oob = |(base & hi_mask);
endmodule

// File: rtl/ste_cap_ident.sv
module ste_cap_ident
  import ste_dec_pkg::*;
(
  input  logic [1:0] cap_sel,
  output logic       id_s1,
  output logic       id_s2
);
  always_comb begin
    case (cap_sel)
      CAP_S2:   begin id_s1 = 1'b0; id_s2 = 1'b1; end
      CAP_NEST: begin id_s1 = 1'b1; id_s2 = 1'b1; end
      default:  begin id_s1 = 1'b1; id_s2 = 1'b0; end
    endcase
  end
endmodule

// File: rtl/ste_cfg_decoder.sv
module ste_cfg_decoder
  import ste_dec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int T0SZ_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cap_sel,
  output logic              cap_s1,
  output logic              cap_s2,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              ent_valid,
  input  logic [2:0]        ent_cfg,
  input  logic [1:0]        s2_gran,
  input  logic [2:0]        s2_ps,
  input  logic [T0SZ_W-1:0] s2_t0sz,
  input  logic [ADDR_W-1:0] s2_base,
  input  logic [2:0]        impl_oas,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_abort,
  output logic              rsp_bypass,
  output logic              rsp_s1,
  output logic              rsp_s2,
  output logic [6:0]        rsp_eff_ps,
  output logic              rsp_t0sz_ok,
  output logic              rsp_bad
);
  logic             c_abort, c_bypass, c_s1, c_s2, c_bad;
  logic [EFF_W-1:0] z_eff;
  logic             z_t0ok, z_oob;
  ste_res_t         res_d, res_q;
  logic             take;

  ste_cap_ident u_cap (
    .cap_sel(cap_sel), .id_s1(cap_s1), .id_s2(cap_s2)
  );

  ste_cfg_class u_cls (
    .ent_valid(ent_valid), .ent_cfg(ent_cfg),
    .is_abort(c_abort), .is_bypass(c_bypass),
    .s1_on(c_s1), .s2_on(c_s2), .cfg_bad(c_bad)
  );

  ste_s2_size #(.ADDR_W(ADDR_W), .T0SZ_W(T0SZ_W)) u_size (
    .gran(s2_gran), .ps_code(s2_ps), .impl_code(impl_oas),
    .t0sz(s2_t0sz), .base(s2_base),
    .eff_ps(z_eff), .t0sz_ok(z_t0ok), .base_oob(z_oob)
  );

  always_comb begin
    res_d.abort   = c_abort;
    res_d.bypass  = c_bypass;
    res_d.s1_en   = c_s1;
    res_d.s2_en   = c_s2;
    res_d.eff_ps  = c_s2 ? z_eff : '0;
    res_d.t0sz_ok = c_s2 & z_t0ok;
    res_d.bad     = c_bad | (c_s2 & z_oob);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (take) begin
        rsp_valid <= 1'b1;
        res_q     <= res_d;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign rsp_abort   = res_q.abort;
  assign rsp_bypass  = res_q.bypass;
  assign rsp_s1      = res_q.s1_en;
  assign rsp_s2      = res_q.s2_en;
  assign rsp_eff_ps  = res_q.eff_ps;
  assign rsp_t0sz_ok = res_q.t0sz_ok;
  assign rsp_bad     = res_q.bad;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(res_q)));

  assert_invalid_bad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ent_valid) |=> (rsp_bad && !rsp_s1 && !rsp_s2 && !rsp_abort));

  assert_abort_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort) |-> (!rsp_bypass && !rsp_s1 && !rsp_s2 && !rsp_bad));

  assert_cap48_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s2_gran != GRAN_64K) |=> (rsp_eff_ps <= 7'd48));

  assert_top_bit_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ent_valid && ent_cfg == CFG_S2 && s2_base[ADDR_W-1]) |=> rsp_bad);
endmodule

// File: tb/sim_ste_cfg_decoder.sv
module sim_ste_cfg_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cap_sel;
  logic        cap_s1, cap_s2;
  logic        req_valid, req_ready;
  logic        ent_valid;
  logic [2:0]  ent_cfg;
  logic [1:0]  s2_gran;
  logic [2:0]  s2_ps;
  logic [5:0]  s2_t0sz;
  logic [63:0] s2_base;
  logic [2:0]  impl_oas;
  logic        rsp_valid, rsp_ready;
  logic        rsp_abort, rsp_bypass, rsp_s1, rsp_s2, rsp_t0sz_ok, rsp_bad;
  logic [6:0]  rsp_eff_ps;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ste_cfg_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cap_sel(cap_sel), .cap_s1(cap_s1), .cap_s2(cap_s2),
    .req_valid(req_valid), .req_ready(req_ready), .ent_valid(ent_valid),
    .ent_cfg(ent_cfg), .s2_gran(s2_gran), .s2_ps(s2_ps), .s2_t0sz(s2_t0sz),
    .s2_base(s2_base), .impl_oas(impl_oas), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_abort(rsp_abort), .rsp_bypass(rsp_bypass),
    .rsp_s1(rsp_s1), .rsp_s2(rsp_s2), .rsp_eff_ps(rsp_eff_ps),
    .rsp_t0sz_ok(rsp_t0sz_ok), .rsp_bad(rsp_bad)
  );

  function automatic int bits_of(input int c);
    case (c)
      0: return 32; 1: return 36; 2: return 40; 3: return 42;
      4: return 44; 5: return 48; default: return 52;
    endcase
  endfunction

  // Expected {abort,bypass,s1,s2,eff[6:0],t0ok,bad} per R2..R11
  function automatic logic [12:0] model(input logic ev, input logic [2:0] cfg,
      input logic [1:0] gr, input logic [2:0] ps, input logic [5:0] t0,
      input logic [63:0] base, input logic [2:0] impl);
    logic ab = 0, by = 0, a1 = 0, a2 = 0, ok = 0, bd = 0;
    int e = 0, lim, fl;
    if (!ev) bd = 1;
    else case (cfg)
      3'b000: ab = 1;
      3'b100: by = 1;
      3'b101: a1 = 1;
      3'b110: a2 = 1;
      3'b111: begin a1 = 1; a2 = 1; end
      default: bd = 1;
    endcase
    if (a2) begin
      e = bits_of((ps < impl) ? int'(ps) : int'(impl));
      if (gr != 2'b01 && e > 48) e = 48;
      lim = 64 - e;
      fl = (gr == 2'b01) ? lim : ((lim < 16) ? 16 : lim);
      ok = (int'(t0) >= fl);
      bd = ((base >> e) != 64'd0);
    end
    return {ab, by, a1, a2, 7'(e), ok, bd};
  endfunction

  function automatic logic [12:0] got();
    return {rsp_abort, rsp_bypass, rsp_s1, rsp_s2, rsp_eff_ps, rsp_t0sz_ok, rsp_bad};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ev, input logic [2:0] cfg, input logic [1:0] gr,
      input logic [2:0] ps, input logic [5:0] t0, input logic [63:0] base,
      input logic [2:0] impl);
    ent_valid = ev; ent_cfg = cfg; s2_gran = gr; s2_ps = ps;
    s2_t0sz = t0; s2_base = base; impl_oas = impl;
  endtask

  task automatic one(input string tag, input logic ev, input logic [2:0] cfg,
      input logic [1:0] gr, input logic [2:0] ps, input logic [5:0] t0,
      input logic [63:0] base, input logic [2:0] impl);
    logic [12:0] exp;
    @(negedge clk);
    drive(ev, cfg, gr, ps, t0, base, impl);
    req_valid = 1'b1;
    exp = model(ev, cfg, gr, ps, t0, base, impl);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    drive(1'b0, 3'b000, 2'b00, 3'b000, 6'd0, 64'd0, 3'b000);
    check("R1 valid", 64'(rsp_valid), 64'd1);
    check(tag, 64'(got()), 64'(exp));
  endtask

  initial begin
    logic [12:0] first, second;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1; cap_sel = 2'b00;
    drive(1'b0, 3'b000, 2'b00, 3'b000, 6'd0, 64'd0, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 reset req_ready", 64'(req_ready), 64'd1);

    // R12 capability identification
    for (int k = 0; k < 4; k++) begin
      cap_sel = 2'(k);
      #1;
      check("R12 cap", 64'({cap_s1, cap_s2}),
            64'((k == 1) ? 2'b01 : (k == 2) ? 2'b11 : 2'b10));
    end

    // R2 invalid entry ignores a stage-2 code
    one("R2 invalid", 1'b0, 3'b110, 2'b00, 3'd2, 6'd40, 64'hFFFF_FFFF_FFFF_FFFF, 3'd5);
    // R3 / R4: priority masks base check
    one("R3 abort", 1'b1, 3'b000, 2'b00, 3'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
    one("R4 bypass", 1'b1, 3'b100, 2'b00, 3'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
    // R5 stage encodings
    one("R5 s1 only", 1'b1, 3'b101, 2'b00, 3'd6, 6'd20, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6);
    one("R5 s2 only", 1'b1, 3'b110, 2'b00, 3'd3, 6'd30, 64'h1000, 3'd6);
    one("R5 nested", 1'b1, 3'b111, 2'b01, 3'd6, 6'd12, 64'h1000, 3'd6);
    // R6 illegal codes
    for (int c = 1; c < 4; c++)
      one("R6 illegal cfg", 1'b1, 3'(c), 2'b00, 3'd5, 6'd30, 64'd0, 3'd5);
    // R7 code map, R8 min selection (64KB granule keeps 52)
    for (int c = 0; c < 8; c++) begin
      one("R7 map", 1'b1, 3'b110, 2'b01, 3'(c), 6'd63, 64'd0, 3'd7);
      one("R8 min impl", 1'b1, 3'b110, 2'b01, 3'd7, 6'd63, 64'd0, 3'(c));
    end
    // R9 48 cap for non-64KB granules
    one("R9 cap 4K", 1'b1, 3'b110, 2'b00, 3'd6, 6'd63, 64'd0, 3'd6);
    one("R9 cap 16K", 1'b1, 3'b110, 2'b10, 3'd7, 6'd63, 64'd0, 3'd7);
    // R10 thresholds
    one("R10 64K at", 1'b1, 3'b110, 2'b01, 3'd6, 6'd12, 64'd0, 3'd6);
    one("R10 64K below", 1'b1, 3'b110, 2'b01, 3'd6, 6'd11, 64'd0, 3'd6);
    one("R10 4K floor at", 1'b1, 3'b110, 2'b00, 3'd6, 6'd16, 64'd0, 3'd6);
    one("R10 4K floor below", 1'b1, 3'b110, 2'b00, 3'd6, 6'd15, 64'd0, 3'd6);
    one("R10 32b below", 1'b1, 3'b110, 2'b00, 3'd0, 6'd31, 64'd0, 3'd5);
    // R11 base edge
    one("R11 base at eff", 1'b1, 3'b110, 2'b00, 3'd5, 6'd20, 64'h0001_0000_0000_0000, 3'd5);
    one("R11 base below eff", 1'b1, 3'b110, 2'b00, 3'd5, 6'd20, 64'h0000_FFFF_FFFF_F000, 3'd5);
    one("R11 base 52", 1'b1, 3'b111, 2'b01, 3'd6, 6'd20, 64'h0010_0000_0000_0000, 3'd6);

    // R1 back-pressure: result frozen, queued request waits
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(1'b1, 3'b110, 2'b00, 3'd2, 6'd30, 64'd0, 3'd4);
    first = model(1'b1, 3'b110, 2'b00, 3'd2, 6'd30, 64'd0, 3'd4);
    req_valid = 1'b1;
    @(negedge clk);
    drive(1'b1, 3'b100, 2'b00, 3'd0, 6'd0, 64'd0, 3'd0);
    second = model(1'b1, 3'b100, 2'b00, 3'd0, 6'd0, 64'd0, 3'd0);
    for (int k = 0; k < 3; k++) begin
      check("R1 stall ready", 64'(req_ready), 64'd0);
      check("R1 stall hold", 64'(got()), 64'(first));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 drain next", 64'(got()), 64'(second));
    check("R1 drain valid", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    check("R1 empty", 64'(rsp_valid), 64'd0);

    // Random mix: R2..R11
    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++) begin
      logic [63:0] b;
      b = {$urandom, $urandom} >> $urandom_range(63, 0);
      one("R8 R9 R10 R11 random", ($urandom_range(9, 0) != 0), 3'($urandom_range(7, 0)),
          2'($urandom_range(3, 0)), 3'($urandom_range(7, 0)), 6'($urandom_range(63, 0)),
          b, 3'($urandom_range(7, 0)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule